// File: doc/BRIEF.md
# Buffered Single-Slope PWM Timer

This block is a 16-bit ramp timer that drives four pulse-width-modulated waveform pins. A power-of-two clock divider produces a count enable; on each enabled cycle the counter steps between zero (BOTTOM) and a programmable TOP held in the period register, then wraps. Each of the four channels raises its waveform at the wrap and drops it when the counter reaches the channel's compare value, so the compare value sets the duty cycle and the period value sets the frequency.

Software programs the block through a single-cycle write port. Period and compare values can be written in two ways. A direct write changes the active value at once. A buffered write is held in a shadow and applied only at the next wrap, so a waveform in progress is never cut short. Per-channel enable and polarity bits shape the pins. An overflow flag and four compare-match flags are sticky, are cleared by writing ones, and feed a single interrupt line through enable masks.

Top module: `pwm_slope_timer`

## Requirements
- R1: The counter advances only while the enable bit (control bit 0) is 1 and the mode field (control bits 7:5) equals 3'b011; any other mode code, or enable 0, holds the count, and each enabled pin then sits at its polarity bit.
- R2: With direction (control bit 4) at 0, each count step goes from N to N+1, and from any value at or above the period register to 0.
- R3: With direction at 1, each count step goes from N to N-1, and from 0 to the period value in force after that step.
- R4: Counting up, a channel's pre-polarity waveform is high exactly while the count is below its compare value, from the first wrap on.
- R5: Counting down with a compare value not above the period, a channel's pre-polarity waveform is high exactly while the count is above its compare value.
- R6: A compare value of 0 keeps that channel's pre-polarity waveform low for the whole period in both directions.
- R7: Writes to the active period (address 1) and active compares (addresses 3 to 6) take effect on the next count step, without waiting for a wrap.
- R8: Writes to the period shadow (address 2) and compare shadows (addresses 7 to 10) are applied only at the next wrap, and each shadow is applied once; a later wrap with no new shadow write leaves the active value as it is.
- R9: Divider code S in control bits 3:1 makes the counter step once every 1, 2, 4, 8, 16, 64, 256 or 1024 clocks for S = 0 to 7.
- R10: Output configuration (address 11) bits 3:0 enable the pins and bits 7:4 invert them; a disabled pin is 0.
- R11: The overflow flag is set at each wrap and compare flag n when the count reaches compare value n; flags stay set until a 1 is written to their bit at address 13 (bit 0 overflow, bits 4:1 compares), and the interrupt line is the OR of flags masked by the enables at address 12 (same bit layout).
- R12: After reset the count is 0, all pins are 0, all flags are 0 and the interrupt line is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 16 | Register write data |
| wave_o | output | 4 | Waveform pins, one per channel |
| count_o | output | 16 | Current counter value |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| cmp_flag_o | output | 4 | Sticky compare-match flags |
| irq_o | output | 1 | Masked interrupt request |

## Verification
The assertions watch, on every cycle, that an idle timer holds its count, that each wrap lands on 0 going up or on the period going down, that count enables never appear while idle, that a disabled pin stays at 0 and that a set overflow flag survives until cleared. The waveform shape against every compare and period pairing, the one-shot nature of shadow transfers, immediate direct writes and the exact divider intervals depend on sequences of writes and counts, so only the bench scenarios show them.

// File: rtl/pwm_timer_pkg.sv
// Shared constants, control layout and divider decode for the PWM timer.
// Assumes the divider counter is wide enough for the largest ratio (1024).
package pwm_timer_pkg;

    localparam int PRE_W = 10;
    localparam logic [2:0] MODE_SINGLE = 3'b011;

    // Control word layout, least significant field last.
    typedef struct packed {
        logic [2:0] mode;
        logic       dir;
        logic [2:0] div_sel;
        logic       en;
    } ctrl_t;

    // Low-bit mask whose all-ones state marks a count enable for each divider code.
    function automatic logic [PRE_W-1:0] div_mask(input logic [2:0] sel);
        logic [PRE_W-1:0] m;
        case (sel)
            3'd0:    m = PRE_W'(0);
            3'd1:    m = PRE_W'(1);
            3'd2:    m = PRE_W'(3);
            3'd3:    m = PRE_W'(7);
            3'd4:    m = PRE_W'(15);
            3'd5:    m = PRE_W'(63);
            3'd6:    m = PRE_W'(255);
            default: m = PRE_W'(1023);
        endcase
        return m;
    endfunction

endpackage

// File: rtl/pwm_prescaler.sv
// Free-running divider producing a one-cycle count enable.
// Assumes the divider restarts from zero whenever the timer is idle.
module pwm_prescaler
    import pwm_timer_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [2:0] div_sel,
    output logic       tick
);

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] mask;

    // Decode the divider code into a low-bit mask.
    always_comb mask = div_mask(div_sel);

    // Advance the divider while running, clear it while idle.
    always_ff @(posedge clk) begin
        if (!rst_n)    pre_q <= '0;
        else if (!run) pre_q <= '0;
        else           pre_q <= pre_q + 1'b1;
    end

    assign tick = run && ((pre_q & mask) == mask);

endmodule

// File: rtl/pwm_shadow_reg.sv
// Active register with a one-deep shadow and a pending flag.
// A direct write wins over a shadow transfer in the same cycle; a shadow
// transfer happens only on update while the pending flag is set.
module pwm_shadow_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_act,
    input  logic         wr_buf,
    input  logic [W-1:0] wdata,
    input  logic         update,
    output logic [W-1:0] act_q,
    output logic [W-1:0] act_nx
);

    logic [W-1:0] buf_q;
    logic         vld_q;

    // Next active value: direct write, pending shadow at update, or hold.
    always_comb begin
        act_nx = act_q;
        if (wr_act)               act_nx = wdata;
        else if (update && vld_q) act_nx = buf_q;
    end

    // Register the active value.
    always_ff @(posedge clk) begin
        if (!rst_n) act_q <= '0;
        else        act_q <= act_nx;
    end

    // Capture shadow writes.
    always_ff @(posedge clk) begin
        if (!rst_n)      buf_q <= '0;
        else if (wr_buf) buf_q <= wdata;
    end

    // Pending flag: set by a shadow write, dropped once applied.
    always_ff @(posedge clk) begin
        if (!rst_n)      vld_q <= 1'b0;
        else if (wr_buf) vld_q <= 1'b1;
        else if (update) vld_q <= 1'b0;
    end

endmodule

// File: rtl/pwm_ramp_counter.sv
// Single-direction ramp counter between zero and the period value.
// Counting up, any value at or above the period wraps to zero; counting down,
// zero reloads with the period value in force after the step.
module pwm_ramp_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         dir,
    input  logic [W-1:0] per_q,
    input  logic [W-1:0] per_nx,
    output logic [W-1:0] cnt_q,
    output logic [W-1:0] cnt_nx,
    output logic         wrap
);

    logic at_end;

    // Detect the end of the ramp for the selected direction.
    always_comb at_end = dir ? (cnt_q == '0) : (cnt_q >= per_q);

    assign wrap = tick && at_end;

    // Compute the next count value.
    always_comb begin
        if (!tick)      cnt_nx = cnt_q;
        else if (at_end) cnt_nx = dir ? per_nx : '0;
        else            cnt_nx = dir ? (cnt_q - 1'b1) : (cnt_q + 1'b1);
    end

    // Register the count.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_nx;
    end

endmodule

// File: rtl/pwm_compare_channel.sv
// One waveform channel: raised at the wrap when its compare value is
// non-zero, dropped when the next count equals the compare value.
// Assumes cnt_nx and cmp_nx are the values that hold after the edge.
module pwm_compare_channel #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         wrap,
    input  logic [W-1:0] cnt_nx,
    input  logic [W-1:0] cmp_nx,
    input  logic         run,
    input  logic         ch_en,
    input  logic         ch_pol,
    output logic         pin,
    output logic         match
);

    logic wave_q;
    logic wave_d;

    // Compare the upcoming count with the upcoming compare value.
    always_comb match = tick && (cnt_nx == cmp_nx);

    // Decide the next raw waveform level.
    always_comb begin
        if (wrap)       wave_d = (cmp_nx != '0) && (cnt_nx != cmp_nx);
        else if (match) wave_d = 1'b0;
        else            wave_d = wave_q;
    end

    // Register the raw waveform.
    always_ff @(posedge clk) begin
        if (!rst_n) wave_q <= 1'b0;
        else        wave_q <= wave_d;
    end

    assign pin = ch_en & ((run & wave_q) ^ ch_pol);

endmodule

// File: rtl/pwm_slope_timer.sv
// Top of the buffered single-slope PWM timer: register decode, sticky flags,
// and the prescaler, counter, period shadow and per-channel instances.
// Assumes one register write per cycle and 16-bit write data.
module pwm_slope_timer
    import pwm_timer_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [NUM_CH-1:0] wave_o,
    output logic [CNT_W-1:0]  count_o,
    output logic              ovf_flag_o,
    output logic [NUM_CH-1:0] cmp_flag_o,
    output logic              irq_o
);

    localparam int A_CTRL    = 0;
    localparam int A_PER     = 1;
    localparam int A_PER_BUF = 2;
    localparam int A_CMP0    = 3;
    localparam int A_CBUF0   = A_CMP0 + NUM_CH;
    localparam int A_OUTCFG  = A_CBUF0 + NUM_CH;
    localparam int A_IRQEN   = A_OUTCFG + 1;
    localparam int A_FLAGCLR = A_IRQEN + 1;
    localparam int FLAG_W    = NUM_CH + 1;

    ctrl_t              ctrl_q;
    logic [NUM_CH-1:0]  ch_en_q;
    logic [NUM_CH-1:0]  ch_pol_q;
    logic [FLAG_W-1:0]  irq_en_q;
    logic [FLAG_W-1:0]  flag_q;
    logic [FLAG_W-1:0]  flag_clr;
    logic [FLAG_W-1:0]  flag_set;
    logic               run;
    logic               tick;
    logic               wrap;
    logic [CNT_W-1:0]   per_q;
    logic [CNT_W-1:0]   per_nx;
    logic [CNT_W-1:0]   cnt_q;
    logic [CNT_W-1:0]   cnt_nx;
    logic [NUM_CH-1:0]  match;
    logic [CNT_W-1:0]   cmp_nx [NUM_CH];
    logic [CNT_W-1:0]   unused_cmp_q [NUM_CH];

    // Control register write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (wr_en && wr_addr == ADDR_W'(A_CTRL))
            ctrl_q <= ctrl_t'(wr_data[7:0]);
    end

    // Output enable and polarity register write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ch_en_q  <= '0;
            ch_pol_q <= '0;
        end else if (wr_en && wr_addr == ADDR_W'(A_OUTCFG)) begin
            ch_en_q  <= wr_data[NUM_CH-1:0];
            ch_pol_q <= wr_data[2*NUM_CH-1:NUM_CH];
        end
    end

    // Interrupt enable register write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_en_q <= '0;
        else if (wr_en && wr_addr == ADDR_W'(A_IRQEN))
            irq_en_q <= wr_data[FLAG_W-1:0];
    end

    // Write-one-to-clear mask and new events for the flags.
    always_comb begin
        flag_clr = (wr_en && wr_addr == ADDR_W'(A_FLAGCLR)) ? wr_data[FLAG_W-1:0] : '0;
        flag_set = {match, wrap};
    end

    // Sticky flags; a new event wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= (flag_q & ~flag_clr) | flag_set;
    end

    assign run = ctrl_q.en && (ctrl_q.mode == MODE_SINGLE);

    pwm_prescaler u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .div_sel (ctrl_q.div_sel),
        .tick    (tick)
    );

    pwm_shadow_reg #(.W(CNT_W)) u_per (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_act (wr_en && wr_addr == ADDR_W'(A_PER)),
        .wr_buf (wr_en && wr_addr == ADDR_W'(A_PER_BUF)),
        .wdata  (wr_data),
        .update (wrap),
        .act_q  (per_q),
        .act_nx (per_nx)
    );

    pwm_ramp_counter #(.W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .dir    (ctrl_q.dir),
        .per_q  (per_q),
        .per_nx (per_nx),
        .cnt_q  (cnt_q),
        .cnt_nx (cnt_nx),
        .wrap   (wrap)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        pwm_shadow_reg #(.W(CNT_W)) u_cmp (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_act (wr_en && wr_addr == ADDR_W'(A_CMP0 + i)),
            .wr_buf (wr_en && wr_addr == ADDR_W'(A_CBUF0 + i)),
            .wdata  (wr_data),
            .update (wrap),
            .act_q  (unused_cmp_q[i]),
            .act_nx (cmp_nx[i])
        );

        pwm_compare_channel #(.W(CNT_W)) u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick   (tick),
            .wrap   (wrap),
            .cnt_nx (cnt_nx),
            .cmp_nx (cmp_nx[i]),
            .run    (run),
            .ch_en  (ch_en_q[i]),
            .ch_pol (ch_pol_q[i]),
            .pin    (wave_o[i]),
            .match  (match[i])
        );
    end

    assign count_o    = cnt_q;
    assign ovf_flag_o = flag_q[0];
    assign cmp_flag_o = flag_q[FLAG_W-1:1];
    assign irq_o      = |(flag_q & irq_en_q);

endmodule

// File: rtl/pwm_slope_timer_chk.sv
// Property checker for the PWM timer, attached to the top by bind.
// Assumes the bound signals are the top's count enable, run state,
// direction, active period and overflow clear strobe.
module pwm_slope_timer_chk #(
    parameter int W = 16,
    parameter int N = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic         run,
    input logic         tick,
    input logic         dir,
    input logic [W-1:0] per_q,
    input logic [W-1:0] count,
    input logic [N-1:0] pins,
    input logic [N-1:0] ch_en,
    input logic         ovf_flag,
    input logic         clr_ovf
);

    assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(count));

    assert_up_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !dir && count >= per_q) |=> (count == '0));

    assert_down_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && dir && count == '0) |=> (count == per_q));

    assert_tick_needs_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> run);

    assert_gated_pin_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pins & ~ch_en) == '0);

    assert_ovf_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !clr_ovf) |=> ovf_flag);

endmodule

bind pwm_slope_timer pwm_slope_timer_chk #(.W(CNT_W), .N(NUM_CH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .tick     (tick),
    .dir      (ctrl_q.dir),
    .per_q    (per_q),
    .count    (count_o),
    .pins     (wave_o),
    .ch_en    (ch_en_q),
    .ovf_flag (ovf_flag_o),
    .clr_ovf  (flag_clr[0])
);

// File: tb/sim_pwm_slope_timer.sv
// Self-checking bench: sweeps period, compare and direction, then covers
// shadow transfers, direct writes, divider codes, idle modes and flags.
module sim_pwm_slope_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [3:0]  wave_o;
    logic [15:0] count_o;
    logic        ovf_flag_o;
    logic [3:0]  cmp_flag_o;
    logic        irq_o;

    int n_chk = 0;
    int n_fail = 0;
    int cm [4];

    pwm_slope_timer u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .wave_o     (wave_o),
        .count_o    (count_o),
        .ovf_flag_o (ovf_flag_o),
        .cmp_flag_o (cmp_flag_o),
        .irq_o      (irq_o)
    );

    always #2 clk = ~clk;

    // Called at a falling edge; the write lands on the next rising edge.
    task automatic wr(input int a, input int d);
        wr_en   = 1'b1;
        wr_addr = 4'(a);
        wr_data = 16'(d);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int ctrl_word(input int en, input int sel, input int dir, input int mode);
        return en | (sel << 1) | (dir << 4) | (mode << 5);
    endfunction

    initial begin
        #(4 * 190000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int prev;
        int cnt;
        int maxc;
        int n;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12: reset state
        chk(count_o == 0, "R12 count", count_o, 0);
        chk(wave_o == 0, "R12 pins", wave_o, 0);
        chk(ovf_flag_o == 0 && cmp_flag_o == 0, "R12 flags", {cmp_flag_o, ovf_flag_o}, 0);
        chk(irq_o == 0, "R12 irq", irq_o, 0);

        // R2 R3 R4 R5 R6: sweep of direction, period and compare values
        for (int d = 0; d < 2; d++) begin
            for (int p = 0; p < 6; p++) begin
                for (int c = 0; c < 7; c++) begin
                    if (d == 1 && c > p) continue;
                    wr(0, 0);
                    wr(1, p);
                    for (int i = 0; i < 4; i++) begin
                        cm[i] = (d == 1) ? (c + i) % (p + 1) : (c + i) % (p + 2);
                        wr(3 + i, cm[i]);
                    end
                    wr(11, 16'h8F);
                    wr(0, ctrl_word(1, 0, d, 3));
                    repeat (16) @(negedge clk);
                    prev = count_o;
                    for (int k = 0; k < 3 * (p + 1); k++) begin
                        int exp_c;
                        @(negedge clk);
                        cnt = count_o;
                        if (d == 1) exp_c = (prev == 0) ? p : prev - 1;
                        else        exp_c = (prev >= p) ? 0 : prev + 1;
                        chk(cnt == exp_c, (d == 1) ? "R3 step" : "R2 step", cnt, exp_c);
                        for (int i = 0; i < 4; i++) begin
                            int ew;
                            int ep;
                            if (d == 1) ew = (cm[i] != 0 && cnt > cm[i]) ? 1 : 0;
                            else        ew = (cm[i] != 0 && cnt < cm[i]) ? 1 : 0;
                            ep = (i == 3) ? (ew ^ 1) : ew;
                            chk(int'(wave_o[i]) == ep,
                                (cm[i] == 0) ? "R6 zero compare" : ((d == 1) ? "R5 down wave" : "R4 up wave"),
                                wave_o[i], ep);
                        end
                        prev = cnt;
                    end
                end
            end
        end

        // R8: shadow writes wait for the wrap
        wr(0, 0);
        wr(1, 9);
        wr(3, 3);
        wr(11, 16'h0F);
        wr(0, ctrl_word(1, 0, 0, 3));
        repeat (20) @(negedge clk);
        while (count_o != 5) @(negedge clk);
        wr(7, 7);
        wr(2, 4);
        maxc = 0;
        while (count_o != 0) begin
            chk(int'(wave_o[0]) == ((count_o < 3) ? 1 : 0), "R8 old compare kept", wave_o[0], (count_o < 3) ? 1 : 0);
            if (count_o > maxc) maxc = count_o;
            @(negedge clk);
        end
        chk(maxc == 9, "R8 old period kept", maxc, 9);
        for (int k = 0; k < 10; k++) begin
            chk(count_o <= 4, "R8 new period", count_o, 4);
            chk(wave_o[0] == 1'b1, "R8 new compare", wave_o[0], 1);
            @(negedge clk);
        end

        // R7: direct writes act within the current period
        while (count_o != 1) @(negedge clk);
        wr(1, 20);
        wr(3, 3);
        chk(count_o == 3, "R7 count position", count_o, 3);
        chk(wave_o[0] == 1'b0, "R7 direct compare", wave_o[0], 0);
        maxc = 0;
        while (count_o != 0) begin
            if (count_o > maxc) maxc = count_o;
            @(negedge clk);
        end
        chk(maxc == 20, "R7 direct period", maxc, 20);
        // R8: the consumed shadow is not applied again
        for (int k = 0; k < 21; k++) begin
            chk(int'(wave_o[0]) == ((count_o < 3) ? 1 : 0), "R8 shadow applied once", wave_o[0], (count_o < 3) ? 1 : 0);
            @(negedge clk);
        end

        // R9: divider intervals
        wr(1, 1000);
        for (int s = 0; s < 8; s++) begin
            int div;
            div = (s < 5) ? (1 << s) : (1 << (2 * s - 4));
            wr(0, ctrl_word(1, s, 0, 3));
            prev = count_o;
            while (count_o == prev) @(negedge clk);
            prev = count_o;
            n = 0;
            do begin
                @(negedge clk);
                n++;
            end while (count_o == prev);
            chk(n == div, "R9 divider interval", n, div);
        end

        // R1 R10: idle for non-selected modes or enable low
        wr(11, 16'hF5);
        for (int m = 0; m < 4; m++) begin
            int cw;
            case (m)
                0: cw = ctrl_word(1, 0, 0, 5);
                1: cw = ctrl_word(1, 0, 0, 2);
                2: cw = ctrl_word(1, 0, 0, 4);
                default: cw = ctrl_word(0, 0, 0, 3);
            endcase
            wr(0, cw);
            prev = count_o;
            repeat (30) @(negedge clk);
            chk(count_o == 16'(prev), "R1 idle holds count", count_o, prev);
            chk(wave_o == 4'b0101, "R1 R10 idle pin level", wave_o, 5);
        end
        wr(0, ctrl_word(1, 0, 0, 3));
        prev = count_o;
        repeat (3) @(negedge clk);
        chk(count_o != 16'(prev), "R1 selected mode runs", count_o, prev + 3);
        chk(wave_o[1] == 1'b0 && wave_o[3] == 1'b0, "R10 disabled pins low", wave_o, 0);

        // R11: sticky flags, write-one clear, masked interrupt
        wr(0, 0);
        wr(13, 16'h1F);
        chk(ovf_flag_o == 0 && cmp_flag_o == 0, "R11 cleared", {cmp_flag_o, ovf_flag_o}, 0);
        wr(12, 1);
        wr(1, 3);
        wr(3, 2);
        wr(0, ctrl_word(1, 0, 0, 3));
        repeat (12) @(negedge clk);
        wr(0, 0);
        chk(ovf_flag_o == 1'b1, "R11 overflow set", ovf_flag_o, 1);
        chk(cmp_flag_o[0] == 1'b1, "R11 compare set", cmp_flag_o[0], 1);
        chk(irq_o == 1'b1, "R11 irq overflow", irq_o, 1);
        wr(13, 1);
        chk(ovf_flag_o == 1'b0, "R11 overflow cleared", ovf_flag_o, 0);
        chk(cmp_flag_o[0] == 1'b1, "R11 compare sticky", cmp_flag_o[0], 1);
        chk(irq_o == 1'b0, "R11 irq masked", irq_o, 0);
        wr(12, 2);
        chk(irq_o == 1'b1, "R11 irq compare", irq_o, 1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule